// File: doc/BRIEF.md
# Zero-Skipping Activation Broadcast Unit

This unit feeds a column-wise matrix-vector engine. When started, it walks an input activation vector in ascending index order, reading each entry out of a set of activation memory banks. Each bank word holds several activations. A selector picks the addressed activation out of the returned bank word, and a zero detector drops every activation that equals zero. Only non-zero values go on. Each of them enters a FIFO together with its column index.

The head of the FIFO is offered to all processing elements at once. It is one activation per cycle, presented as a valid / value / column-index triple. It advances only when the processing elements signal ready, so a zero column costs the engine no compute cycle at all. The FIFO builds up a backlog while the engine is busy. Fetching pauses while the FIFO has no free room. Once every index has been read and the FIFO has drained, the unit raises an end-of-vector flag for a single cycle and returns to idle.

Top module: `sparse_act_feeder`

## Requirements
- R1: After reset, `bc_valid`, `eov` and every bit of `bank_rd_en` are 0.
- R2: Every non-zero activation at index i < `vec_len` is broadcast exactly once, in ascending index order, with `bc_col` = i. A zero-valued activation is never broadcast.
- R3: Activation i sits in bank (i/4) mod 8 at word address i/32. Within that 64-bit word it occupies bits [16*(i mod 4) +: 16]. Bank data is returned one cycle after its read enable.
- R4: While `bc_valid` is 1 and `pe_ready` is 0, the next cycle shows `bc_valid` still 1, with `bc_data` and `bc_col` unchanged.
- R5: When the processing elements stall for longer than it takes to fill the 32-entry FIFO, no activation is lost or duplicated. Fetching pauses, and no write is made into a full FIFO.
- R6: `eov` is high for exactly one cycle. It comes after all non-zero activations of the vector have been accepted, and `bc_valid` is 0 in that cycle.
- R7: A vector whose entries are all zero produces no broadcast, and `eov` is still raised.
- R8: A `start` pulse that arrives while a vector is in progress is ignored. The running vector completes unchanged.
- R9: With `vec_len` = 0, `eov` is raised and no bank read is issued.
- R10: At most one bit of `bank_rd_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a vector (accepted only when idle) |
| vec_len | input | 16 | Number of activations in the vector, sampled at start |
| bank_rd_en | output | 8 | Per-bank read enable |
| bank_rd_addr | output | 6 | Word address shared by all banks |
| bank_rd_data | input | 512 | Concatenated 64-bit read data of all banks, bank 0 in the low bits |
| pe_ready | input | 1 | All processing elements can take an activation |
| bc_valid | output | 1 | Broadcast activation valid |
| bc_data | output | 16 | Broadcast activation value |
| bc_col | output | 16 | Column index of the broadcast activation |
| eov | output | 1 | End-of-vector, one-cycle pulse |

## Verification
The bench targets a stall that lasts far longer than the FIFO takes to fill. A design with a wrong room check would then drop or overwrite activations, and the stream would show gaps or repeats. It runs vectors with zeros at the first and last index and with lengths that cross bank and lane boundaries. A selector that picks the wrong lane or bank shows up as values or column indices that do not match. It also runs an all-zero vector and a zero-length vector, where a weak end condition would hang or would issue reads. A second start is sent in the middle of a vector; a design that restarts on it would truncate the expected stream.

// File: rtl/act_feed_pkg.sv
package act_feed_pkg;
  localparam int unsigned VAL_W = 16;
  localparam int unsigned COL_W = 16;

  typedef struct packed {
    logic [COL_W-1:0] col;
    logic [VAL_W-1:0] val;
  } feed_item_t;
endpackage

// File: rtl/act_fetch_seq.sv
module act_fetch_seq #(
  parameter int unsigned LANES      = 4,
  parameter int unsigned BANKS      = 8,
  parameter int unsigned BANK_AW    = 6,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned IDX_W      = 16,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned BANK_W    = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  vec_len,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              fifo_empty,
  output logic [BANKS-1:0]  bank_rd_en,
  output logic [BANK_AW-1:0] bank_rd_addr,
  output logic              rd_vld_q,
  output logic [LANE_W-1:0] rd_lane_q,
  output logic [BANK_W-1:0] rd_bank_q,
  output logic [IDX_W-1:0]  rd_idx_q,
  output logic              eov
);
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] len_q;
  logic             load_len;
  logic             issue;
  logic             done;
  logic [CNT_W:0]   occ;
  logic [BANK_W-1:0] cur_bank;

  assign cur_bank     = idx_q[LANE_W +: BANK_W];
  assign bank_rd_addr = idx_q[LANE_W + BANK_W +: BANK_AW];
  // entries held plus the one in flight from the banks
  assign occ   = {1'b0, fifo_count} + {{CNT_W{1'b0}}, rd_vld_q};
  assign issue = busy_q && (idx_q != len_q) && (occ < FIFO_DEPTH);
  assign done  = busy_q && (idx_q == len_q) && !rd_vld_q && fifo_empty;
  assign eov   = done;

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_en
      assign bank_rd_en[b] = issue && (cur_bank == b);
    end
  endgenerate

  always_comb begin
    busy_d   = busy_q;
    idx_d    = idx_q;
    load_len = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d   = 1'b1;
        idx_d    = '0;
        load_len = 1'b1;
      end
    end else if (done) begin
      busy_d = 1'b0;
    end else if (issue) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      idx_q     <= '0;
      len_q     <= '0;
      rd_vld_q  <= 1'b0;
      rd_lane_q <= '0;
      rd_bank_q <= '0;
      rd_idx_q  <= '0;
    end else begin
      busy_q   <= busy_d;
      idx_q    <= idx_d;
      rd_vld_q <= issue;
      if (load_len) len_q <= vec_len;
      if (issue) begin
        rd_lane_q <= idx_q[LANE_W-1:0];
        rd_bank_q <= cur_bank;
        rd_idx_q  <= idx_q;
      end
    end
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_rd_en)); // R10
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (bank_rd_en == '0)); // R9
endmodule

// File: rtl/act_lane_select.sv
module act_lane_select
  import act_feed_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BANKS  = 8,
  parameter int unsigned IDX_W  = 16,
  localparam int unsigned WORD_W = LANES * VAL_W,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned BANK_W = $clog2(BANKS)
) (
  input  logic                    rd_vld,
  input  logic [LANE_W-1:0]       rd_lane,
  input  logic [BANK_W-1:0]       rd_bank,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic [BANKS*WORD_W-1:0] bank_rd_data,
  output logic                    push,
  output feed_item_t              item
);
  logic [WORD_W-1:0] word;
  logic [VAL_W-1:0]  val;

  assign word     = bank_rd_data[rd_bank*WORD_W +: WORD_W];
  assign val      = word[rd_lane*VAL_W +: VAL_W];
  assign push     = rd_vld && (val != '0);
  assign item.val = val;
  assign item.col = COL_W'(rd_idx);
endmodule

// File: rtl/act_sync_fifo.sv
module act_sync_fifo
  import act_feed_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  feed_item_t       din,
  input  logic             pop,
  output feed_item_t       head,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  feed_item_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [CNT_W-1:0] cnt_d;
  logic             do_pop;

  assign empty  = (count == '0);
  assign do_pop = pop && !empty;
  assign head   = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = count;
    if (push)   wr_d = (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (do_pop) rd_d = (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    if (push && !do_pop)      cnt_d = count + 1'b1;
    else if (!push && do_pop) cnt_d = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      count <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count < DEPTH) || do_pop); // R5
endmodule

// File: rtl/sparse_act_feeder.sv
module sparse_act_feeder
  import act_feed_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned BANKS      = 8,
  parameter int unsigned BANK_AW    = 6,
  parameter int unsigned FIFO_DEPTH = 32,
  parameter int unsigned IDX_W      = 16,
  localparam int unsigned WORD_W    = LANES * VAL_W,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned BANK_W    = $clog2(BANKS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [IDX_W-1:0]        vec_len,
  output logic [BANKS-1:0]        bank_rd_en,
  output logic [BANK_AW-1:0]      bank_rd_addr,
  input  logic [BANKS*WORD_W-1:0] bank_rd_data,
  input  logic                    pe_ready,
  output logic                    bc_valid,
  output logic [VAL_W-1:0]        bc_data,
  output logic [COL_W-1:0]        bc_col,
  output logic                    eov
);
  logic              rd_vld;
  logic [LANE_W-1:0] rd_lane;
  logic [BANK_W-1:0] rd_bank;
  logic [IDX_W-1:0]  rd_idx;
  logic              push;
  feed_item_t        item;
  feed_item_t        head;
  logic              fifo_empty;
  logic [CNT_W-1:0]  fifo_count;

  act_fetch_seq #(
    .LANES(LANES), .BANKS(BANKS), .BANK_AW(BANK_AW),
    .FIFO_DEPTH(FIFO_DEPTH), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
    .fifo_count(fifo_count), .fifo_empty(fifo_empty),
    .bank_rd_en(bank_rd_en), .bank_rd_addr(bank_rd_addr),
    .rd_vld_q(rd_vld), .rd_lane_q(rd_lane), .rd_bank_q(rd_bank),
    .rd_idx_q(rd_idx), .eov(eov)
  );

  act_lane_select #(
    .LANES(LANES), .BANKS(BANKS), .IDX_W(IDX_W)
  ) u_sel (
    .rd_vld(rd_vld), .rd_lane(rd_lane), .rd_bank(rd_bank), .rd_idx(rd_idx),
    .bank_rd_data(bank_rd_data), .push(push), .item(item)
  );

  act_sync_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(item),
    .pop(pe_ready), .head(head), .empty(fifo_empty), .count(fifo_count)
  );

  assign bc_valid = !fifo_empty;
  assign bc_data  = head.val;
  assign bc_col   = head.col;

  AST_BC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && !pe_ready) |=> (bc_valid && $stable(bc_data) && $stable(bc_col))); // R4
  AST_NO_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> (bc_data != '0)); // R2
  AST_EOV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    eov |=> !eov); // R6
  AST_EOV_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    eov |-> !bc_valid); // R6
endmodule

// File: tb/sparse_act_feeder_tb.sv
`timescale 1ns/1ps
module sparse_act_feeder_tb;
  localparam int BANKS = 8;
  localparam int LANES = 4;
  localparam int WORDS = 64;

  logic             clk, rst_n, start, pe_ready;
  logic [15:0]      vec_len;
  logic [BANKS-1:0] bank_rd_en;
  logic [5:0]       bank_rd_addr;
  logic [BANKS*64-1:0] bank_rd_data;
  logic             bc_valid, eov;
  logic [15:0]      bc_data, bc_col;

  sparse_act_feeder u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
    .bank_rd_en(bank_rd_en), .bank_rd_addr(bank_rd_addr),
    .bank_rd_data(bank_rd_data), .pe_ready(pe_ready),
    .bc_valid(bc_valid), .bc_data(bc_data), .bc_col(bc_col), .eov(eov)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [63:0] mem [BANKS*WORDS];
  int checks = 0, errors = 0;
  int cyc = 0, reads = 0, multi_en = 0, eov_count = 0, bcasts = 0;
  int ready_mode = 0, stall_until = 0;
  logic [31:0] expq [$];
  logic prev_stall = 0, prev_eov = 0;
  logic [15:0] prev_d, prev_c;

  always @(posedge clk) begin
    for (int b = 0; b < BANKS; b++)
      if (bank_rd_en[b]) bank_rd_data[b*64 +: 64] <= mem[b*WORDS + bank_rd_addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ready driver
  initial begin
    pe_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      case (ready_mode)
        0: pe_ready = 1'b1;
        1: pe_ready = (cyc % 3) != 0;
        default: pe_ready = (cyc >= stall_until);
      endcase
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (|bank_rd_en) reads++;
      if ($countones(bank_rd_en) > 1) multi_en++;
      if (prev_stall) begin
        chk(bc_valid && bc_data == prev_d && bc_col == prev_c, "R4 hold",
            int'(bc_data), int'(prev_d));
      end
      prev_stall = bc_valid && !pe_ready;
      prev_d = bc_data; prev_c = bc_col;
      if (bc_valid && pe_ready) begin
        bcasts++;
        if (expq.size() == 0) begin
          chk(1'b0, "R2 unexpected broadcast", int'(bc_col), -1);
        end else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(bc_data == e[15:0] && bc_col == e[31:16], "R2/R3 item",
              int'({bc_col, bc_data}), int'(e));
        end
      end
      if (eov) begin
        eov_count++;
        chk(!prev_eov, "R6 single pulse", 1, 0);
        chk(expq.size() == 0, "R6 drained at eov", expq.size(), 0);
      end
      prev_eov = eov;
    end
  end

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [15:0] gen(input int p, input int i);
    case (p)
      0: gen = (i % 3 == 0) ? 16'd0 : 16'(i * 7 + 1);
      1: gen = 16'd0;
      2: gen = 16'(i + 100);
      default: gen = (i == 0 || i % 5 == 2) ? 16'd0 : 16'(16'h8000 ^ i);
    endcase
  endfunction

  task automatic load(input int len, input int p);
    for (int w = 0; w < BANKS*WORDS; w++) mem[w] = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < len; i++) begin
      logic [15:0] v;
      int w;
      v = gen(p, i);
      w = i / LANES;
      mem[(w % BANKS)*WORDS + w / BANKS][16*(i % LANES) +: 16] = v;
      if (v != 0) expq.push_back({16'(i), v});
    end
  endtask

  task automatic run(input int len, input int p, input bit restart, input string tag);
    int e0, b0, exp_n, t;
    e0 = eov_count; b0 = bcasts;
    load(len, p);
    exp_n = expq.size();
    @(negedge clk); start = 1'b1; vec_len = 16'(len);
    @(negedge clk); start = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      start = 1'b1; vec_len = 16'd5;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (eov_count == e0 && t < 5000) begin @(negedge clk); t++; end
    chk(eov_count == e0 + 1, {tag, " eov seen"}, eov_count - e0, 1);
    chk(bcasts - b0 == exp_n, {tag, " broadcast count"}, bcasts - b0, exp_n);
    repeat (4) @(negedge clk);
    chk(eov_count == e0 + 1 && bcasts - b0 == exp_n, {tag, " quiet after eov"},
        eov_count - e0, 1);
    expq.delete();
  endtask

  initial begin
    int r0;
    rst_n = 1'b0; start = 1'b0; vec_len = '0;
    repeat (3) @(negedge clk);
    chk(!bc_valid && !eov && bank_rd_en == '0, "R1 reset state",
        int'({bc_valid, eov, bank_rd_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    ready_mode = 0; run(40, 0, 0, "R2 mixed zeros");
    run(37, 3, 0, "R3 edge zeros odd length");
    run(20, 1, 0, "R7 all-zero");
    ready_mode = 2; stall_until = cyc + 200;
    run(100, 2, 0, "R5 long stall");
    ready_mode = 1; run(50, 0, 1, "R8 restart ignored");
    ready_mode = 0;
    r0 = reads;
    run(0, 2, 0, "R9 zero length");
    chk(reads == r0, "R9 no reads", reads - r0, 0);
    chk(multi_en == 0, "R10 one bank per cycle", multi_en, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule